// File: doc/BRIEF.md
# Multi-Lane Fragment Aligner and Word Reassembler

This block sits behind a bank of per-lane deserializers that run on the frame clock. Every frame cycle it receives a fixed number of bits from each data lane; together they form one fragment. A bunch-crossing word is sent as a fixed number of consecutive fragments. The block works out which fragment starts a word, puts the fragments of a word back together and presents the whole word once per bunch crossing with a one-cycle valid strobe.

Framing relies on a dedicated marker bit in every fragment. The transmitter sets it only in the first fragment of each word. The block hunts for that marker. It confirms the framing over several words before declaring lock, and it tolerates a single stray mismatch while locked. Two mismatches in a row drop the lock and raise an error flag. The error flag stays up until the block locks again. The orbit marker travels as an ordinary bit of the word and is also brought out on a pin of its own.

The default setting uses 11 lanes of 6 bits and 5 fragments, giving a 330-bit word. The same RTL also serves 11 lanes of 4 bits with 7 fragments, giving a 308-bit word.

Top module: `lane_frame_aligner`

## Requirements
- R1: Lane l supplies fragment bits [l*LANE_BITS +: LANE_BITS]. Fragment k of a word occupies word bits [k*FRAG_W +: FRAG_W], so the first fragment fills the least significant bits.
- R2: The marker is fragment bit 0 (MARK_BIT). While searching, the block takes the first fragment whose marker is 1 as the start of a word. This holds whatever number of marker-free fragments came before it.
- R3: Lock is declared after 4 consecutive words show the marker in their first fragment. `locked_o` rises on the clock edge that takes in the first fragment of the fourth such word. Before that edge it is 0.
- R4: While locked, `word_valid_o` is high for exactly one cycle: the cycle after the clock edge that takes in the last fragment of a word. At the same time `word_o` carries that word bit for bit. While unlocked, `word_valid_o` stays 0. Successive valid pulses under continuous lock are FRAGS cycles apart.
- R5: While locked, a single word whose first fragment lacks the marker leaves lock in place, and that word is still delivered, provided the next word carries the marker again.
- R6: A second consecutive word without the marker drops `locked_o` and raises `align_err_o` on the edge that takes in its first fragment. That word is not delivered. `align_err_o` is never high while `locked_o` is high.
- R7: After a loss of lock, the block searches again and re-locks under the rule of R3. `align_err_o` clears on the same edge on which `locked_o` rises.
- R8: `orbit_o` equals word bit 1 (ORBIT_BIT) of the delivered word while `word_valid_o` is high, and is 0 otherwise.
- R9: With LANE_BITS=4 and FRAGS=7, the block recovers 308-bit words under the same rules.
- R10: While `rst_ni` is low at a clock edge, `locked_o`, `align_err_o`, `word_valid_o` and `orbit_o` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| lane_data_i | input | LANES*LANE_BITS (66) | Deserialized bits of all lanes for this frame cycle |
| word_o | output | FRAG_W*FRAGS (330) | Reassembled bunch-crossing word |
| word_valid_o | output | 1 | One-cycle strobe marking a new word on `word_o` |
| orbit_o | output | 1 | Orbit bit of the delivered word, qualified by valid |
| locked_o | output | 1 | Fragment framing confirmed |
| align_err_o | output | 1 | Framing lost; held until the next lock |

## Verification
A wrong fragment counter shows up as a word with its fragments rotated. It appears on the very next valid strobe, at most FRAGS cycles after the fault, and the marker bit then sits at a nonzero fragment position. A wrong run counter in the lock logic moves the rising or falling edge of `locked_o` by whole words. It also makes words appear or vanish around lock changes, so the word scoreboard sees a missing or unexpected word within one word time. A stuck error flag or a broken strobe spacing is visible on the status pins at once.

// File: rtl/frame_align_pkg.sv
`timescale 1ns/1ps
// Shared types for the fragment aligner.
package frame_align_pkg;
    // Framing states of the alignment tracker.
    typedef enum logic [1:0] {
        FA_SEARCH = 2'd0,   // looking for any marker fragment
        FA_HUNT   = 2'd1,   // marker found, confirming over several words
        FA_LOCKED = 2'd2    // framing confirmed, words are delivered
    } fa_state_e;
endpackage

// File: rtl/fa_align_fsm.sv
`timescale 1ns/1ps
// Alignment tracker: counts fragments modulo FRAGS and runs the
// search / confirm / locked state machine on the marker bit.
// Assumes the marker is 1 only in the first fragment of a word.
module fa_align_fsm
    import frame_align_pkg::*;
#(
    parameter int FRAGS      = 5,
    parameter int LOCK_WORDS = 4,
    parameter int MISS_LIMIT = 2,
    localparam int SLOT_W    = $clog2(FRAGS),
    localparam int RUN_MAX   = (LOCK_WORDS > MISS_LIMIT) ? LOCK_WORDS : MISS_LIMIT,
    localparam int RUN_W     = $clog2(RUN_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              marker_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o,
    output logic              locked_o,
    output logic              align_err_o
);
    fa_state_e         state_q;
    logic [SLOT_W-1:0] cnt_q;
    logic [RUN_W-1:0]  run_q;
    logic              err_q;
    logic              slot0;

    // Slot of the fragment now at the input; a searching tracker treats it as slot 0.
    always_comb begin
        slot_o = (state_q == FA_SEARCH) ? '0 : cnt_q;
        slot0  = (slot_o == '0);
    end

    // Fragment counter and framing state machine.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= FA_SEARCH;
            cnt_q   <= '0;
            run_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            cnt_q <= (slot_o == SLOT_W'(FRAGS - 1)) ? '0 : slot_o + SLOT_W'(1);
            case (state_q)
                FA_SEARCH: begin
                    if (marker_i) begin
                        if (LOCK_WORDS == 1) begin
                            state_q <= FA_LOCKED;
                            run_q   <= '0;
                            err_q   <= 1'b0;
                        end else begin
                            state_q <= FA_HUNT;
                            run_q   <= RUN_W'(1);
                        end
                    end
                end
                FA_HUNT: begin
                    if (slot0) begin
                        if (!marker_i) begin
                            state_q <= FA_SEARCH;
                            run_q   <= '0;
                        end else if (run_q == RUN_W'(LOCK_WORDS - 1)) begin
                            state_q <= FA_LOCKED;
                            run_q   <= '0;
                            err_q   <= 1'b0;
                        end else begin
                            run_q <= run_q + RUN_W'(1);
                        end
                    end
                end
                FA_LOCKED: begin
                    if (slot0) begin
                        if (marker_i) begin
                            run_q <= '0;
                        end else if (run_q == RUN_W'(MISS_LIMIT - 1)) begin
                            state_q <= FA_SEARCH;
                            run_q   <= '0;
                            err_q   <= 1'b1;
                        end else begin
                            run_q <= run_q + RUN_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= FA_SEARCH;
                    run_q   <= '0;
                end
            endcase
        end
    end

    // Status and word-completion outputs.
    always_comb begin
        locked_o    = (state_q == FA_LOCKED);
        last_o      = locked_o && (slot_o == SLOT_W'(FRAGS - 1));
        align_err_o = err_q;
    end
endmodule

// File: rtl/fa_word_gearbox.sv
`timescale 1ns/1ps
// Word gearbox: holds the first FRAGS-1 fragments by slot. On the last
// slot it joins them with the live fragment into one registered word.
// Assumes slot_i is valid every cycle and last_i marks a deliverable word.
module fa_word_gearbox #(
    parameter int FRAG_W  = 66,
    parameter int FRAGS   = 5,
    localparam int SLOT_W = $clog2(FRAGS),
    localparam int WORD_W = FRAG_W * FRAGS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FRAG_W-1:0] frag_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              last_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;

    for (genvar s = 0; s < FRAGS - 1; s++) begin : g_slot
        logic [FRAG_W-1:0] hold_q;
        // Capture the fragment that belongs to slot s.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)                       hold_q <= '0;
            else if (slot_i == SLOT_W'(s))     hold_q <= frag_i;
        end
        assign word_d[s*FRAG_W +: FRAG_W] = hold_q;
    end
    assign word_d[(FRAGS-1)*FRAG_W +: FRAG_W] = frag_i;

    // Register the completed word and its strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= last_i;
            if (last_i) word_q <= word_d;
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/lane_frame_aligner.sv
`timescale 1ns/1ps
// Multi-lane fragment aligner and word reassembler (top).
// Merges the lane slices into one fragment per frame cycle, tracks the
// marker framing and delivers each reassembled word with a strobe.
// Assumes every fragment carries a marker bit at MARK_BIT.
module lane_frame_aligner #(
    parameter int LANES      = 11,
    parameter int LANE_BITS  = 6,
    parameter int FRAGS      = 5,
    parameter int MARK_BIT   = 0,
    parameter int ORBIT_BIT  = 1,
    parameter int LOCK_WORDS = 4,
    parameter int MISS_LIMIT = 2,
    localparam int FRAG_W    = LANES * LANE_BITS,
    localparam int WORD_W    = FRAG_W * FRAGS,
    localparam int SLOT_W    = $clog2(FRAGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FRAG_W-1:0] lane_data_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              orbit_o,
    output logic              locked_o,
    output logic              align_err_o
);
    logic [FRAG_W-1:0] frag;
    logic [SLOT_W-1:0] slot;
    logic              last;

    // Lane l contributes its slice to the fragment.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign frag[l*LANE_BITS +: LANE_BITS] = lane_data_i[l*LANE_BITS +: LANE_BITS];
    end

    fa_align_fsm #(
        .FRAGS      (FRAGS),
        .LOCK_WORDS (LOCK_WORDS),
        .MISS_LIMIT (MISS_LIMIT)
    ) align_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .marker_i    (frag[MARK_BIT]),
        .slot_o      (slot),
        .last_o      (last),
        .locked_o    (locked_o),
        .align_err_o (align_err_o)
    );

    fa_word_gearbox #(
        .FRAG_W (FRAG_W),
        .FRAGS  (FRAGS)
    ) gear_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .frag_i  (frag),
        .slot_i  (slot),
        .last_i  (last),
        .word_o  (word_o),
        .valid_o (word_valid_o)
    );

    // Orbit bit of the delivered word, qualified by the strobe.
    assign orbit_o = word_valid_o & word_o[ORBIT_BIT];
endmodule

// File: rtl/lane_frame_aligner_chk.sv
`timescale 1ns/1ps
// Property checker for lane_frame_aligner, attached by bind.
// Tracks the spacing of valid strobes with a counter.
module lane_frame_aligner_chk #(
    parameter int FRAGS   = 5,
    localparam int GAP_W  = $clog2(FRAGS + 1) + 1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic word_valid_o,
    input logic orbit_o,
    input logic locked_o,
    input logic align_err_o
);
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Cycles since the last strobe, and whether one was seen under the current lock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (!locked_o)         seen_q <= 1'b0;
            else if (word_valid_o) seen_q <= 1'b1;
            if (word_valid_o)      gap_q <= '0;
            else if (gap_q != '1)  gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_valid_o |-> locked_o);                                        // R4
    AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_valid_o |=> !word_valid_o);                                   // R4
    AST_VALID_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && seen_q) |-> (gap_q == GAP_W'(FRAGS - 1)));       // R4
    AST_ERR_NOT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        align_err_o |-> !locked_o);                                        // R6
    AST_ERR_ON_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(align_err_o) |-> $fell(locked_o));                           // R6
    AST_LOSS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(locked_o) |-> align_err_o);                                  // R6
    AST_ORBIT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        orbit_o |-> word_valid_o);                                         // R8
endmodule

bind lane_frame_aligner lane_frame_aligner_chk #(.FRAGS(FRAGS)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_o (word_valid_o),
    .orbit_o      (orbit_o),
    .locked_o     (locked_o),
    .align_err_o  (align_err_o)
);

// File: tb/lane_frame_aligner_tb_top.sv
`timescale 1ns/1ps
// One scenario run against one parameter setting of the aligner.
module lane_frame_aligner_env #(
    parameter int    LANE_BITS = 6,
    parameter int    FRAGS     = 5,
    parameter string CFG       = "R4"
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic done
);
    localparam int LANES  = 11;
    localparam int FRAG_W = LANES * LANE_BITS;
    localparam int WORD_W = FRAG_W * FRAGS;

    logic [FRAG_W-1:0] lane_data;
    logic [WORD_W-1:0] word;
    logic              valid, orbit, locked, aerr;
    logic [WORD_W-1:0] exp_q[$];
    bit                mon_on;

    lane_frame_aligner #(.LANES(LANES), .LANE_BITS(LANE_BITS), .FRAGS(FRAGS)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .lane_data_i  (lane_data),
        .word_o       (word),
        .word_valid_o (valid),
        .orbit_o      (orbit),
        .locked_o     (locked),
        .align_err_o  (aerr)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", CFG, tag, act, exp);
        end
    endtask

    // Random word; marker bit 0 of fragment 0 set only when good.
    function automatic logic [WORD_W-1:0] make_word(input bit good);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W; i++) w[i] = 1'($urandom_range(1, 0));
        for (int k = 0; k < FRAGS; k++) w[k*FRAG_W] = (k == 0) && good;
        return w;
    endfunction

    // Transmit gearbox model: one fragment per frame cycle, first fragment first.
    task automatic send_frags(input logic [WORD_W-1:0] w, input int lo, input int hi);
        for (int k = lo; k <= hi; k++) begin
            lane_data = w[k*FRAG_W +: FRAG_W];
            @(negedge clk);
        end
    endtask

    task automatic send_word(input logic [WORD_W-1:0] w, input bit emit);
        if (emit) exp_q.push_back(w);
        send_frags(w, 0, FRAGS - 1);
    endtask

    // Random offset of marker-free fragments.
    task automatic send_junk();
        int n = $urandom_range(2 * FRAGS, 1);
        for (int j = 0; j < n; j++) begin
            lane_data = FRAG_W'($urandom()) ^ {FRAG_W{1'($urandom_range(1, 0))}};
            lane_data[0] = 1'b0;
            @(negedge clk);
        end
    endtask

    // Monitor: pop the scoreboard on each strobe and compare.
    always @(negedge clk) begin
        if (mon_on && valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 strobe with no word expected", word, '0);
            end else begin
                logic [WORD_W-1:0] e;
                e = exp_q.pop_front();
                chk(word == e, "R1 R4 word content", word, e);
                chk(orbit == e[1], "R8 orbit bit", WORD_W'(orbit), WORD_W'(e[1]));
            end
        end
    end

    initial begin
        logic [WORD_W-1:0] w;
        n_chk = 0; n_fail = 0; done = 1'b0; mon_on = 1'b0;
        lane_data = '0;
        repeat (3) @(negedge clk);
        chk(!locked && !aerr && !valid && !orbit, "R10 reset outputs",
            WORD_W'({locked, aerr, valid, orbit}), '0);
        wait (rst_n);
        @(negedge clk);
        mon_on = 1'b1;

        // R2 R3: random offset, then four good words; only the fourth is delivered.
        send_junk();
        for (int i = 0; i < 3; i++) send_word(make_word(1'b1), 1'b0);
        chk(!locked, "R3 no lock after three words", WORD_W'(locked), '0);
        w = make_word(1'b1);
        exp_q.push_back(w);
        send_frags(w, 0, 0);
        chk(locked, "R3 lock on fourth marker", WORD_W'(locked), 1);
        chk(!aerr, "R3 no error on first lock", WORD_W'(aerr), 0);
        send_frags(w, 1, FRAGS - 1);
        for (int i = 0; i < 6; i++) send_word(make_word(1'b1), 1'b1);

        // R5: isolated misses keep lock and deliver the word.
        send_word(make_word(1'b0), 1'b1);
        chk(locked, "R5 lock kept after one miss", WORD_W'(locked), 1);
        send_word(make_word(1'b1), 1'b1);
        send_word(make_word(1'b0), 1'b1);
        send_word(make_word(1'b1), 1'b1);
        chk(locked && !aerr, "R5 lock kept, no error", WORD_W'({locked, aerr}), 2);

        // R6: two misses in a row drop lock at the second word's first fragment.
        send_word(make_word(1'b0), 1'b1);
        w = make_word(1'b0);
        send_frags(w, 0, 0);
        chk(!locked, "R6 lock dropped", WORD_W'(locked), 0);
        chk(aerr, "R6 error raised", WORD_W'(aerr), 1);
        send_frags(w, 1, FRAGS - 1);
        chk(aerr && !locked, "R6 error held while searching", WORD_W'({locked, aerr}), 1);

        // R7: new offset, re-lock after four good words, error clears.
        send_junk();
        for (int i = 0; i < 3; i++) send_word(make_word(1'b1), 1'b0);
        chk(aerr && !locked, "R7 still searching before fourth word", WORD_W'({locked, aerr}), 1);
        w = make_word(1'b1);
        exp_q.push_back(w);
        send_frags(w, 0, 0);
        chk(locked && !aerr, "R7 re-lock clears error", WORD_W'({locked, aerr}), 2);
        send_frags(w, 1, FRAGS - 1);
        for (int i = 0; i < 3; i++) send_word(make_word(1'b1), 1'b1);

        lane_data = '0;
        repeat (2) @(negedge clk);
        mon_on = 1'b0;
        chk(exp_q.size() == 0, {CFG, " every expected word delivered"},
            WORD_W'(exp_q.size()), '0);
        done = 1'b1;
    end
endmodule

// Bench top: clock, reset, both settings, watchdog and summary.
module lane_frame_aligner_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c0, f0, c1, f1;
    logic d0, d1;
    bit   timed_out = 1'b0;

    always #2.5 clk = ~clk;

    lane_frame_aligner_env #(.LANE_BITS(6), .FRAGS(5), .CFG("R4 default"))
        env_main_i (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(d0));
    lane_frame_aligner_env #(.LANE_BITS(4), .FRAGS(7), .CFG("R9 alternate"))
        env_alt_i  (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(d1));

    initial begin
        int checks, fails;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        fork
            wait (d0 && d1);
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        checks = c0 + c1;
        fails  = f0 + f1;
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule